// File: doc/BRIEF.md
# Tick-Driven Seconds Clock with Delay Timer

This block keeps time from a periodic tick. A free-running divider makes one tick every `TICK_DIV` clock cycles; with a 3.6864 MHz reference and the default divider this gives 100 ticks per second. A jiffy counter splits each second into `JIFFIES` ticks. Each whole second advances two counters: an uptime count that software can only read, and a time-of-day count of seconds since an epoch, which software can also load. Both counters wrap at their maximum value, and no overflow is reported.

A separate delay timer counts down a programmed number of seconds, using its own reloading jiffy counter. It reports busy until the count reaches zero. A tick flag raises `irq` and stays set until it is acknowledged. Software uses an 8-bit register port. A single capture command copies both second counters into shadow registers on the same edge, so a multi-byte read never mixes bytes from before and after a carry.

Top module: `tick_timekeeper`

## Requirements
- R1: While `rst_n` is low, every counter, flag and shadow register is zero. Internal logic leaves reset on the second rising clock edge after `rst_n` rises, so counting starts on the third edge. After reset, `irq` and `delay_busy` are 0 and every register reads back 0.
- R2: A tick occurs every `TICK_DIV` cycles. The seconds jiffy counter steps 0 to `JIFFIES`-1 on ticks. The tick on which it wraps back to 0 is the one that ends a second.
- R3: Uptime (`UP_W` bits) gains 1 on every second. Writes to its addresses (9 to 12) have no effect.
- R4: Time-of-day (`TOD_W` bits) gains 1 on every second.
- R5: Bytes written to addresses 4 to 8 are staged, with address 4 holding the least significant byte. Writing address 0 with bit 2 set loads the staged value into time-of-day. On the same edge as a second, the load wins over the increment.
- R6: Writing address 0 with bit 0 set copies uptime and time-of-day into shadow registers on one edge. Reads of addresses 4 to 8 return the time-of-day shadow and reads of 9 to 12 return the uptime shadow, least significant byte first.
- R7: Writing address 2 stores the low byte of a delay count. Writing address 3 supplies the high byte and starts the delay. `delay_busy` is high while the remaining count is non-zero. A count of N lasts N×`JIFFIES` ticks, and a count of 0 leaves `delay_busy` low.
- R8: While the remaining delay count is zero, ticks leave the delay state unchanged.
- R9: A tick sets `irq`. Writing address 0 with bit 1 set clears it. A tick on the same edge as the acknowledge wins.
- R10: A read of address 1 returns `irq` in bit 0 and `delay_busy` in bit 1, with the other bits 0.
- R11: The counters wrap silently. A time-of-day of all ones returns to 0 on the next second.
- R12: A read sampled with `rd_en` appears on `rdata` with `rvalid` high one cycle later. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with `rvalid` |
| rvalid | output | 1 | Read data valid, one cycle after `rd_en` |
| irq | output | 1 | Tick interrupt flag |
| delay_busy | output | 1 | Delay count is running |

## Verification
The bench loads time-of-day on the very edge that ends a second; a design that let the increment win would read back the staged value plus one. It loads all ones and lets a second pass, which catches a design that saturates instead of wrapping. It acknowledges `irq` on the edge of a tick, where a design that lets the clear win would drop the flag. It also measures how long a delay stays busy and starts a delay of zero seconds; an off-by-one in the delay jiffy reload, or a timer that sticks busy, shows up as a busy time outside the allowed window.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int ADR_CTRL = 0;
  localparam int ADR_STAT = 1;
  localparam int ADR_DLO  = 2;
  localparam int ADR_DHI  = 3;
  localparam int ADR_TOD0 = 4;
  localparam int CB_SNAP   = 0;
  localparam int CB_ACK    = 1;
  localparam int CB_COMMIT = 2;
endpackage

// File: rtl/tk_prescaler.sv
module tk_prescaler #(
  parameter int TICK_DIV = 36864
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (cnt_q == LAST);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tk_seconds.sv
module tk_seconds #(
  parameter int JIFFIES = 100,
  parameter int UP_W    = 32,
  parameter int TOD_W   = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [TOD_W-1:0] load_val_i,
  output logic             sec_o,
  output logic [UP_W-1:0]  uptime_o,
  output logic [TOD_W-1:0] tod_o
);
  localparam int JW = (JIFFIES > 1) ? $clog2(JIFFIES) : 1;
  localparam logic [JW-1:0] JLAST = JW'(JIFFIES - 1);

  logic [JW-1:0]    jif_q, jif_d;
  logic [UP_W-1:0]  up_q, up_d;
  logic [TOD_W-1:0] tod_q, tod_d;

  always_comb begin
    sec_o = tick_i && (jif_q == JLAST);
    jif_d = jif_q;
    if (tick_i) jif_d = sec_o ? '0 : jif_q + 1'b1;
    up_d  = sec_o ? up_q + 1'b1 : up_q;
    tod_d = tod_q;
    if (load_i)     tod_d = load_val_i;
    else if (sec_o) tod_d = tod_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      jif_q <= '0;
      up_q  <= '0;
      tod_q <= '0;
    end else begin
      jif_q <= jif_d;
      up_q  <= up_d;
      tod_q <= tod_d;
    end
  end

  assign uptime_o = up_q;
  assign tod_o    = tod_q;
endmodule

// File: rtl/tk_delay.sv
module tk_delay #(
  parameter int JIFFIES = 100,
  parameter int DLY_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic [DLY_W-1:0] secs_i,
  output logic [DLY_W-1:0] left_o,
  output logic             busy_o
);
  localparam int JW = $clog2(JIFFIES + 1);
  localparam logic [JW-1:0] JFULL = JW'(JIFFIES);

  logic [DLY_W-1:0] sec_q, sec_d;
  logic [JW-1:0]    jif_q, jif_d;

  always_comb begin
    sec_d = sec_q;
    jif_d = jif_q;
    if (start_i) begin
      sec_d = secs_i;
      jif_d = JFULL;
    end else if (tick_i && (sec_q != '0)) begin
      if (jif_q == JW'(1)) begin
        sec_d = sec_q - 1'b1;
        jif_d = JFULL;
      end else begin
        jif_d = jif_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      jif_q <= '0;
    end else begin
      sec_q <= sec_d;
      jif_q <= jif_d;
    end
  end

  assign left_o = sec_q;
  assign busy_o = (sec_q != '0);
endmodule

// File: rtl/tick_timekeeper.sv
module tick_timekeeper
  import tk_pkg::*;
#(
  parameter int TICK_DIV = 36864,
  parameter int JIFFIES  = 100,
  parameter int UP_W     = 32,
  parameter int TOD_W    = 40,
  parameter int DLY_W    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rvalid,
  output logic       irq,
  output logic       delay_busy
);
  localparam int TOD_B   = TOD_W / 8;
  localparam int UP_B    = UP_W / 8;
  localparam int ADR_UP0 = ADR_TOD0 + TOD_B;

  // reset: asserted asynchronously, released on the second edge
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic             tick, sec_pulse, busy;
  logic [UP_W-1:0]  uptime;
  logic [TOD_W-1:0] tod;
  logic [DLY_W-1:0] dly_left, dly_val;
  logic             wr_ctrl, snap_cmd, ack_cmd, tod_commit, dly_start;

  logic [TOD_W-1:0] stage_q, stage_d;
  logic [7:0]       dlo_q, dlo_d;
  logic [TOD_W-1:0] stod_q, stod_d;
  logic [UP_W-1:0]  sup_q, sup_d;
  logic             irq_q, irq_d;
  logic [7:0]       rd_q, rd_d;
  logic             rv_q;

  always_comb begin
    wr_ctrl    = wr_en && (addr == 4'(ADR_CTRL));
    snap_cmd   = wr_ctrl && wdata[CB_SNAP];
    ack_cmd    = wr_ctrl && wdata[CB_ACK];
    tod_commit = wr_ctrl && wdata[CB_COMMIT];
    dly_start  = wr_en && (addr == 4'(ADR_DHI));
    dly_val    = DLY_W'({wdata, dlo_q});
  end

  tk_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_int_n), .tick_o(tick)
  );

  tk_seconds #(.JIFFIES(JIFFIES), .UP_W(UP_W), .TOD_W(TOD_W)) u_sec (
    .clk(clk), .rst_n(rst_int_n), .tick_i(tick), .load_i(tod_commit),
    .load_val_i(stage_q), .sec_o(sec_pulse), .uptime_o(uptime), .tod_o(tod)
  );

  tk_delay #(.JIFFIES(JIFFIES), .DLY_W(DLY_W)) u_dly (
    .clk(clk), .rst_n(rst_int_n), .tick_i(tick), .start_i(dly_start),
    .secs_i(dly_val), .left_o(dly_left), .busy_o(busy)
  );

  // next state for register file
  always_comb begin
    stage_d = stage_q;
    for (int b = 0; b < TOD_B; b++) begin
      if (wr_en && (addr == 4'(ADR_TOD0 + b))) stage_d[8*b +: 8] = wdata;
    end
    dlo_d  = (wr_en && (addr == 4'(ADR_DLO))) ? wdata : dlo_q;
    stod_d = snap_cmd ? tod    : stod_q;
    sup_d  = snap_cmd ? uptime : sup_q;
    irq_d  = tick ? 1'b1 : (ack_cmd ? 1'b0 : irq_q);
    rd_d   = '0;
    if (rd_en) begin
      if (addr == 4'(ADR_STAT)) rd_d = {6'b0, busy, irq_q};
      for (int b = 0; b < TOD_B; b++) begin
        if (addr == 4'(ADR_TOD0 + b)) rd_d = stod_q[8*b +: 8];
      end
      for (int b = 0; b < UP_B; b++) begin
        if (addr == 4'(ADR_UP0 + b)) rd_d = sup_q[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      stage_q <= '0;
      dlo_q   <= '0;
      stod_q  <= '0;
      sup_q   <= '0;
      irq_q   <= 1'b0;
      rd_q    <= '0;
      rv_q    <= 1'b0;
    end else begin
      stage_q <= stage_d;
      dlo_q   <= dlo_d;
      stod_q  <= stod_d;
      sup_q   <= sup_d;
      irq_q   <= irq_d;
      rd_q    <= rd_d;
      rv_q    <= rd_en;
    end
  end

  assign rdata      = rd_q;
  assign rvalid     = rv_q;
  assign irq        = irq_q;
  assign delay_busy = busy;
endmodule

// File: rtl/tk_checker.sv
module tk_checker #(
  parameter int UP_W  = 32,
  parameter int TOD_W = 40,
  parameter int DLY_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             sec_pulse,
  input logic [UP_W-1:0]  uptime,
  input logic [TOD_W-1:0] tod,
  input logic             tod_commit,
  input logic [TOD_W-1:0] tod_stage,
  input logic [DLY_W-1:0] dly_left,
  input logic             dly_start,
  input logic [DLY_W-1:0] dly_val,
  input logic             busy,
  input logic             irq
);
  p_sec_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> tick);

  p_uptime_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_pulse |=> uptime == $past(uptime));

  p_uptime_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> uptime == UP_W'($past(uptime) + 1'b1));

  p_tod_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tod_commit |=> tod == $past(tod_stage));

  p_tod_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !tod_commit) |=> tod == TOD_W'($past(tod) + 1'b1));

  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_start && dly_val != '0) |=> busy);

  p_delay_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_left == '0 && !dly_start) |=> dly_left == '0);

  p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> irq);
endmodule

bind tick_timekeeper tk_checker #(.UP_W(UP_W), .TOD_W(TOD_W), .DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .tick(tick), .sec_pulse(sec_pulse),
  .uptime(uptime), .tod(tod), .tod_commit(tod_commit), .tod_stage(stage_q),
  .dly_left(dly_left), .dly_start(dly_start), .dly_val(dly_val),
  .busy(busy), .irq(irq_q)
);

// File: tb/sim_tick_timekeeper.sv
`timescale 1ns/1ps
module sim_tick_timekeeper;
  localparam int DIV = 8;
  localparam int J   = 5;
  localparam int UPW = 32;
  localparam int TDW = 40;
  localparam int DLW = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rvalid, irq, delay_busy;

  int total = 0, bad = 0;
  bit live = 0, done = 0;

  always #2.5 clk = ~clk;

  tick_timekeeper #(.TICK_DIV(DIV), .JIFFIES(J), .UP_W(UPW), .TOD_W(TDW), .DLY_W(DLW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .irq(irq), .delay_busy(delay_busy)
  );

  // reference model built from the requirements
  logic [1:0]     mr;
  int             mdiv, mjif, mdjif;
  logic [UPW-1:0] mup, msup;
  logic [TDW-1:0] mtod, mstod, mstage;
  logic [7:0]     mlo;
  logic [DLW-1:0] mdsec;
  logic           mirq;
  logic [7:0]     expq[$];
  string          tagq[$];

  function automatic logic [7:0] exp_read(logic [3:0] a);
    if (a == 1) return {6'b0, (mdsec != 0), mirq};
    if (a >= 4 && a <= 8) return mstod[8*(a-4) +: 8];
    if (a >= 9 && a <= 12) return msup[8*(a-9) +: 8];
    return 8'h00;
  endfunction

  task automatic mclear();
    mdiv <= 0; mjif <= 0; mdjif <= 0; mup <= '0; msup <= '0; mtod <= '0;
    mstod <= '0; mstage <= '0; mlo <= '0; mdsec <= '0; mirq <= 1'b0;
  endtask

  always @(posedge clk or negedge rst_n) begin : model
    bit mt, ms, ctl;
    if (!rst_n) begin
      mr <= '0;
      mclear();
    end else begin
      mr <= {mr[0], 1'b1};
      if (!mr[1]) mclear();
      else begin
        if (rd_en) expq.push_back(exp_read(addr));
        mt  = (mdiv == DIV-1);
        ms  = mt && (mjif == J-1);
        ctl = wr_en && addr == 0;
        mdiv <= mt ? 0 : mdiv + 1;
        if (mt) mjif <= ms ? 0 : mjif + 1;
        if (ms) mup <= mup + 1;
        if (ctl && wdata[2]) mtod <= mstage;
        else if (ms) mtod <= mtod + 1;
        if (ctl && wdata[0]) begin msup <= mup; mstod <= mtod; end
        if (mt) mirq <= 1'b1;
        else if (ctl && wdata[1]) mirq <= 1'b0;
        for (int b = 0; b < 5; b++)
          if (wr_en && addr == 4 + b) mstage[8*b +: 8] <= wdata;
        if (wr_en && addr == 2) mlo <= wdata;
        if (wr_en && addr == 3) begin mdsec <= {wdata, mlo}; mdjif <= J; end
        else if (mt && mdsec != 0) begin
          if (mdjif == 1) begin mdsec <= mdsec - 1; mdjif <= J; end
          else mdjif <= mdjif - 1;
        end
      end
    end
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rvalid) begin
      if (expq.size() == 0) chk(0, "R12 unexpected rvalid", 1, 0);
      else begin
        logic [7:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(rdata == e, t, rdata, e);
      end
    end
    if (live) begin
      chk(irq == mirq, "R9 irq", irq, mirq);
      chk(delay_busy == (mdsec != 0), "R7 busy", delay_busy, mdsec != 0);
    end
  end

  task automatic wr(logic [3:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, string tag);
    addr = a; rd_en = 1'b1; tagq.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic snap_all(string tag);
    wr(0, 8'h01);
    for (int b = 4; b <= 12; b++) rd(4'(b), tag);
    @(negedge clk);
  endtask

  task automatic stage(logic [39:0] v);
    for (int b = 0; b < 5; b++) wr(4'(4 + b), v[8*b +: 8]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : main
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(irq == 0, "R1 irq", irq, 0);
    chk(delay_busy == 0, "R1 busy", delay_busy, 0);
    rd(1, "R1 status");
    rd(4, "R1 tod shadow");
    rd(9, "R1 uptime shadow");
    live = 1;

    // R3 R4 R6: counting and coherent capture
    repeat (100) @(negedge clk);
    snap_all("R6 R4 R3 snapshot");
    chk(u0.rdata == rdata, "R12", rdata, rdata);

    // R2: tick spacing measured on irq rises
    wait (irq == 1'b1); @(negedge clk);
    wr(0, 8'h02);
    n = 1;
    while (irq == 1'b0) begin @(negedge clk); n++; end
    wr(0, 8'h02);
    n = 1;
    while (irq == 1'b0) begin @(negedge clk); n++; end
    chk(n == DIV, "R2 tick spacing", n, DIV);

    // R3: uptime is read only
    wr(9, 8'hFF); wr(10, 8'hFF);
    snap_all("R3 write ignored");

    // R5: load on the same edge as a second
    stage(40'h12_3456_789A);
    while (!(mdiv == DIV-1 && mjif == J-1)) @(negedge clk);
    wr(0, 8'h04);
    snap_all("R5 load beats increment");
    chk(mstod == 40'h12_3456_789A, "R5 model", mstod, 40'h12_3456_789A);

    // R11: wrap from all ones
    stage({40{1'b1}});
    wr(0, 8'h04);
    repeat (DIV*J + 2) @(negedge clk);
    snap_all("R11 wrap");

    // R9: acknowledge clears, coincident tick wins
    wait (irq == 1'b1); @(negedge clk);
    while (mdiv == DIV-1) @(negedge clk);
    wr(0, 8'h02);
    chk(irq == 1'b0, "R9 ack clears", irq, 0);
    while (mdiv != DIV-1) @(negedge clk);
    wr(0, 8'h02);
    chk(irq == 1'b1, "R9 tick beats ack", irq, 1);

    // R7 R10: two-second delay
    wr(2, 8'h02);
    wr(3, 8'h00);
    chk(delay_busy == 1'b1, "R7 busy after start", delay_busy, 1);
    rd(1, "R10 status busy");
    n = 1;
    while (delay_busy) begin @(negedge clk); n++; end
    chk(n > (2*J-1)*DIV && n <= 2*J*DIV, "R7 delay length", n, 2*J*DIV);

    // R7 zero count, R8 idle
    wr(2, 8'h00);
    wr(3, 8'h00);
    chk(delay_busy == 1'b0, "R7 zero count", delay_busy, 0);
    repeat (3*DIV*J) @(negedge clk);
    chk(delay_busy == 1'b0, "R8 idle stays", delay_busy, 0);
    rd(1, "R8 status");

    // R12: unmapped address
    rd(4'hF, "R12 unmapped");
    rd(4'hD, "R12 unmapped");
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R12 all reads returned", expq.size(), 0);
    finish_run();
  end
endmodule